// File: doc/BRIEF.md
# NAND Page Hamming Parity Generator

This block watches the bytes that cross a flash controller's data register and builds single-error-correcting Hamming parity over them. Each 256-byte chunk of a page gets three parity bytes. One ECC step covers `STEP_BYTES` bytes: 512 when the flash page is 512 bytes or more, 256 for smaller pages. A 512-byte step therefore gives two chunks and six parity bytes. Software finds and corrects the error itself. This block only supplies the parity.

Software drives the block through a 2-bit mode field. For each page it writes clear, then off, then on, and then moves the data. It then writes off and selects read-out. While read-out is selected, reads of the data register return parity bytes instead of flash data. Finally software writes off again. Command and address cycles never reach the parity.

Top module: `nand_ecc_gen`

## Requirements
- R1: The mode field encodes 2'b11 = clear, 2'b00 = off, 2'b01 = accumulate and 2'b10 = read-out. A mode write takes effect on the next cycle. A data strobe in the same cycle as a mode write is handled under the mode that was in force before the write.
- R2: While the mode is clear, all parity accumulators and the byte position are held at zero.
- R3: A strobe with `dat_stb`=1 and `cmd_cyc`=0 in accumulate mode adds one byte to the parity. On reads (`dat_rd`=1) the byte is `flash_byte`; on writes it is `wr_byte`. Each such byte advances the byte position by one.
- R4: Strobes with `cmd_cyc`=1 leave the parity unchanged. So do strobes while the mode is off or read-out.
- R5: Let a be a byte's position within its chunk and p the XOR of its bits.
  - Parity byte 0, bit 2k+1, is the inverted XOR of p over bytes with a[k]=1, and bit 2k is the same over bytes with a[k]=0, for k=0..3.
  - Parity byte 1 holds the same for k=4..7.
  - Parity byte 2, bits 7:2, are the inverted column parities c5..c0 over all bytes: c0 over bits 0,2,4,6; c1 over bits 1,3,5,7; c2 over bits 0,1,4,5; c3 over bits 2,3,6,7; c4 over bits 3:0; c5 over bits 7:4. Bits 1:0 of byte 2 are 1.
- R6: Byte position n belongs to chunk n/256 and to in-chunk position n%256.
- R7: In read-out mode, successive data reads return chunk 0 byte 1, chunk 0 byte 0, chunk 0 byte 2, then the same three bytes for each following chunk.
- R8: The read-out pointer wraps to chunk 0 byte 1 after the last chunk's byte 2. Any mode write sends it back to that start.
- R9: `rd_byte` and `rd_vld` are registered and appear one cycle after a read strobe. Outside read-out mode, `rd_byte` is the `flash_byte` that was strobed.
- R10: After reset the mode is off, `rd_vld` is 0 and the accumulators are zero.
- R11: A step of all-0xFF data, or a step with no data at all, reads out as all-ones parity bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Write strobe for the mode field |
| mode_wdata | input | 2 | New mode value |
| dat_stb | input | 1 | A byte crosses the data register this cycle |
| dat_rd | input | 1 | 1 = host read from flash, 0 = host write |
| cmd_cyc | input | 1 | Strobe is a command or address cycle |
| wr_byte | input | 8 | Byte written by the host |
| flash_byte | input | 8 | Byte read from the flash |
| rd_byte | output | 8 | Data returned to the host |
| rd_vld | output | 1 | rd_byte is valid |

## Verification
Two functions can fall in the same cycle: a mode write and a data strobe.

- The bench drives a mode write to accumulate together with a byte strobe while the mode is off, and expects that byte to be left out.
- It drives a mode write to off together with a strobe while accumulating, and expects that byte to be counted.
- Both outcomes are judged through the parity read out afterwards, compared with a bench model.
- A mode write that lands in the middle of read-out is judged by whether the next read returns chunk 0 byte 1.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  typedef enum logic [1:0] {
    EM_OFF   = 2'b00,
    EM_ON    = 2'b01,
    EM_READ  = 2'b10,
    EM_CLEAR = 2'b11
  } ecc_mode_e;

  localparam int ADDR_W = 8;            // bytes per chunk = 2**ADDR_W
  localparam int LINE_W = 2 * ADDR_W;
  localparam int COL_W  = 6;

  function automatic logic [COL_W-1:0] col_par(input logic [7:0] b);
    logic [COL_W-1:0] c;
    c[0] = b[0] ^ b[2] ^ b[4] ^ b[6];
    c[1] = b[1] ^ b[3] ^ b[5] ^ b[7];
    c[2] = b[0] ^ b[1] ^ b[4] ^ b[5];
    c[3] = b[2] ^ b[3] ^ b[6] ^ b[7];
    c[4] = ^b[3:0];
    c[5] = ^b[7:4];
    return c;
  endfunction

  // returns {byte2, byte1, byte0}, inverted, unused bits set
  function automatic logic [23:0] fmt_par(input logic [LINE_W-1:0] lp,
                                          input logic [COL_W-1:0] cp);
    return {~cp, 2'b11, ~lp[15:8], ~lp[7:0]};
  endfunction
endpackage

// File: rtl/nand_ecc_acc.sv
module nand_ecc_acc
  import nand_ecc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [LINE_W-1:0] lp,
  output logic [COL_W-1:0]  cp
);
  logic              bpar;
  logic [LINE_W-1:0] line_upd;

  always_comb begin
    bpar = ^din;
    for (int k = 0; k < ADDR_W; k++) begin
      line_upd[2*k]   = bpar & ~addr[k];
      line_upd[2*k+1] = bpar &  addr[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      lp <= '0;
      cp <= '0;
    end else if (en) begin
      lp <= lp ^ line_upd;
      cp <= cp ^ col_par(din);
    end
  end
endmodule

// File: rtl/nand_ecc_rdseq.sv
module nand_ecc_rdseq #(
  parameter int NCH  = 2,
  parameter int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            restart,
  input  logic            adv,
  output logic [CH_W-1:0] chunk,
  output logic [1:0]      pos
);
  always_ff @(posedge clk) begin
    if (rst || restart) begin
      chunk <= '0;
      pos   <= 2'd0;
    end else if (adv) begin
      if (pos == 2'd2) begin
        pos   <= 2'd0;
        chunk <= (chunk == CH_W'(NCH - 1)) ? '0 : chunk + 1'b1;
      end else begin
        pos <= pos + 2'd1;
      end
    end
  end
endmodule

// File: rtl/nand_ecc_gen.sv
module nand_ecc_gen
  import nand_ecc_pkg::*;
#(
  parameter int STEP_BYTES = 512
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mode_wr,
  input  logic [1:0] mode_wdata,
  input  logic       dat_stb,
  input  logic       dat_rd,
  input  logic       cmd_cyc,
  input  logic [7:0] wr_byte,
  input  logic [7:0] flash_byte,
  output logic [7:0] rd_byte,
  output logic       rd_vld
);
  localparam int NCH   = STEP_BYTES / (1 << ADDR_W);
  localparam int IDX_W = $clog2(STEP_BYTES);
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int ACC_W = LINE_W + COL_W;

  ecc_mode_e          mode_q;
  logic               acc_en, clr, rd_req;
  logic [IDX_W-1:0]   byte_idx;
  logic [CH_W-1:0]    chunk_sel;
  logic [7:0]         acc_byte;
  logic [NCH*ACC_W-1:0] acc_flat;
  logic [23:0]        fmt_w [NCH];
  logic [CH_W-1:0]    rs_chunk;
  logic [1:0]         rs_pos;
  logic [7:0]         par_sel;

  always_ff @(posedge clk) begin
    if (rst)          mode_q <= EM_OFF;
    else if (mode_wr) mode_q <= ecc_mode_e'(mode_wdata);
  end

  assign clr       = (mode_q == EM_CLEAR);
  assign acc_en    = (mode_q == EM_ON) && dat_stb && !cmd_cyc;
  assign rd_req    = dat_stb && dat_rd;
  assign acc_byte  = dat_rd ? flash_byte : wr_byte;
  assign chunk_sel = CH_W'(byte_idx >> ADDR_W);

  always_ff @(posedge clk) begin
    if (rst || clr)  byte_idx <= '0;
    else if (acc_en) byte_idx <= byte_idx + 1'b1;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chunk
    logic [LINE_W-1:0] lp;
    logic [COL_W-1:0]  cp;
    nand_ecc_acc u_acc (
      .clk  (clk),
      .rst  (rst),
      .clr  (clr),
      .en   (acc_en && (chunk_sel == CH_W'(g))),
      .addr (byte_idx[ADDR_W-1:0]),
      .din  (acc_byte),
      .lp   (lp),
      .cp   (cp)
    );
    assign fmt_w[g] = fmt_par(lp, cp);
    assign acc_flat[g*ACC_W +: ACC_W] = {lp, cp};
  end

  nand_ecc_rdseq #(.NCH(NCH), .CH_W(CH_W)) u_rdseq (
    .clk     (clk),
    .rst     (rst),
    .restart (mode_wr),
    .adv     (rd_req && (mode_q == EM_READ)),
    .chunk   (rs_chunk),
    .pos     (rs_pos)
  );

  always_comb begin
    case (rs_pos)
      2'd0:    par_sel = fmt_w[rs_chunk][15:8];
      2'd1:    par_sel = fmt_w[rs_chunk][7:0];
      default: par_sel = fmt_w[rs_chunk][23:16];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_byte <= '0;
      rd_vld  <= 1'b0;
    end else begin
      rd_vld <= rd_req;
      if (rd_req) rd_byte <= (mode_q == EM_READ) ? par_sel : flash_byte;
    end
  end
endmodule

// File: rtl/nand_ecc_gen_chk.sv
module nand_ecc_gen_chk #(
  parameter int IDX_W = 9,
  parameter int FLAT_W = 44
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        mode_q,
  input logic              acc_en,
  input logic              rd_req,
  input logic              rd_vld,
  input logic [1:0]        rs_pos,
  input logic [IDX_W-1:0]  byte_idx,
  input logic [FLAT_W-1:0] acc_flat
);
  a_r2_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'b11) |=> (acc_flat == '0 && byte_idx == '0));

  a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (!acc_en && mode_q != 2'b11) |=> $stable(acc_flat));

  a_r3_idx_step: assert property (@(posedge clk) disable iff (rst)
    (acc_en && mode_q != 2'b11) |=> byte_idx == IDX_W'($past(byte_idx) + 1'b1));

  a_r9_vld_follows: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_vld);

  a_r9_no_spurious_vld: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !rd_vld);

  always @(posedge clk)
    if (!rst) a_r7_pos_range: assert (rs_pos != 2'd3);
endmodule

bind nand_ecc_gen nand_ecc_gen_chk #(.IDX_W(IDX_W), .FLAT_W(NCH*ACC_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mode_q   (mode_q),
  .acc_en   (acc_en),
  .rd_req   (rd_req),
  .rd_vld   (rd_vld),
  .rs_pos   (rs_pos),
  .byte_idx (byte_idx),
  .acc_flat (acc_flat)
);

// File: tb/nand_ecc_gen_tb.sv
`timescale 1ns/1ps
module nand_ecc_gen_tb;
  localparam int STEP = 512;
  localparam int NCH  = STEP / 256;

  logic clk = 0, rst = 1;
  logic mode_wr = 0, dat_stb = 0, dat_rd = 0, cmd_cyc = 0;
  logic [1:0] mode_wdata = 0;
  logic [7:0] wr_byte = 0, flash_byte = 0, rd_byte;
  logic rd_vld;

  int checks = 0, fails = 0;
  logic [7:0] mdl [STEP];
  int mcnt = 0;

  always #2 clk = ~clk;

  nand_ecc_gen #(.STEP_BYTES(STEP)) u_dut (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .dat_stb(dat_stb), .dat_rd(dat_rd), .cmd_cyc(cmd_cyc),
    .wr_byte(wr_byte), .flash_byte(flash_byte),
    .rd_byte(rd_byte), .rd_vld(rd_vld)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  // expected parity byte w (0,1,2) of chunk c from the requirement text
  function automatic logic [7:0] exp_par(input int c, input int w);
    logic [15:0] lp = '0;
    logic [5:0]  cp = '0;
    for (int a = 0; a < 256; a++) begin
      logic [7:0] b = mdl[c*256 + a];
      logic p = ^b;
      for (int k = 0; k < 8; k++)
        if (a[k]) lp[2*k+1] ^= p; else lp[2*k] ^= p;
      cp[0] ^= b[0]^b[2]^b[4]^b[6];
      cp[1] ^= b[1]^b[3]^b[5]^b[7];
      cp[2] ^= b[0]^b[1]^b[4]^b[5];
      cp[3] ^= b[2]^b[3]^b[6]^b[7];
      cp[4] ^= ^b[3:0];
      cp[5] ^= ^b[7:4];
    end
    if (w == 0) return ~lp[7:0];
    if (w == 1) return ~lp[15:8];
    return {~cp, 2'b11};
  endfunction

  task automatic mdl_clear();
    for (int i = 0; i < STEP; i++) mdl[i] = 8'h00;
    mcnt = 0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk); mode_wr = 1; mode_wdata = m;
    @(negedge clk); mode_wr = 0;
  endtask

  task automatic push(input logic rd, input logic cmd, input logic [7:0] b, input logic counted);
    @(negedge clk);
    dat_stb = 1; dat_rd = rd; cmd_cyc = cmd;
    if (rd) flash_byte = b; else wr_byte = b;
    @(negedge clk);
    dat_stb = 0; cmd_cyc = 0;
    if (counted) begin mdl[mcnt] = b; mcnt++; end
    if (rd) chk("R9 flash passthrough", rd_byte, b);
  endtask

  task automatic read_par(output logic [7:0] v);
    @(negedge clk); dat_stb = 1; dat_rd = 1; cmd_cyc = 0;
    @(negedge clk); dat_stb = 0;
    chk("R9 rd_vld", {7'd0, rd_vld}, 8'd1);
    v = rd_byte;
  endtask

  task automatic check_readout(input string req);
    logic [7:0] v;
    set_mode(2'b00);
    set_mode(2'b10);
    for (int c = 0; c < NCH; c++) begin
      read_par(v); chk({req, " R7 byte1"}, v, exp_par(c, 1));
      read_par(v); chk({req, " R7 byte0"}, v, exp_par(c, 0));
      read_par(v); chk({req, " R5 byte2"}, v, exp_par(c, 2));
    end
    read_par(v); chk({req, " R8 wrap"}, v, exp_par(0, 1));
    set_mode(2'b00);
  endtask

  task automatic start_page();
    set_mode(2'b11); set_mode(2'b00); set_mode(2'b01);
    mdl_clear();
  endtask

  initial begin
    #(4ns * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5eed_1234));
    mdl_clear();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R10 rd_vld after reset", {7'd0, rd_vld}, 8'd0);
    // R10/R11: no data since reset reads as all ones
    check_readout("R10 R11 empty");

    for (int it = 0; it < 6; it++) begin
      start_page();
      for (int n = 0; n < STEP; n++) begin
        logic [7:0] b;
        case (it)
          0: b = 8'hFF;
          1: b = 8'h00;
          2: b = (n == 300) ? 8'h10 : 8'h00;
          default: b = 8'($urandom);
        endcase
        if (it >= 3 && ($urandom % 8) == 0)
          push(1'b0, 1'b1, 8'($urandom), 1'b0);      // R4 command cycle ignored
        push(1'($urandom), 1'b0, b, 1'b1);           // R3 R6
      end
      set_mode(2'b00);
      for (int j = 0; j < 4; j++) push(1'($urandom), 1'b0, 8'($urandom), 1'b0); // R4 off ignored
      check_readout(it == 0 ? "R11 erased" : "R3 R6 page");
    end

    // R1 same-cycle: mode write with strobe uses previous mode
    set_mode(2'b11); set_mode(2'b00); mdl_clear();
    @(negedge clk); mode_wr = 1; mode_wdata = 2'b01; dat_stb = 1; dat_rd = 0; wr_byte = 8'hA5;
    @(negedge clk); mode_wr = 0; dat_stb = 0;
    for (int j = 0; j < 5; j++) push(1'b0, 1'b0, 8'($urandom), 1'b1);
    @(negedge clk); mode_wr = 1; mode_wdata = 2'b00; dat_stb = 1; dat_rd = 0; wr_byte = 8'h3C;
    @(negedge clk); mode_wr = 0; dat_stb = 0;
    mdl[mcnt] = 8'h3C; mcnt++;
    check_readout("R1 same-cycle");

    // R2: clear after data zeroes the parity
    start_page();
    for (int j = 0; j < 20; j++) push(1'b0, 1'b0, 8'($urandom), 1'b0);
    set_mode(2'b11); mdl_clear();
    check_readout("R2 clear");

    // R8: mode write mid read-out restarts pointer
    start_page();
    for (int j = 0; j < 40; j++) push(1'b1, 1'b0, 8'($urandom), 1'b1);
    set_mode(2'b00); set_mode(2'b10);
    read_par(v); read_par(v);
    chk("R7 second read", v, exp_par(0, 0));
    set_mode(2'b10);
    read_par(v);
    chk("R8 restart", v, exp_par(0, 1));
    // R4: reads in read-out mode do not disturb parity
    check_readout("R4 readout stable");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule